// File: doc/BRIEF.md
# Display Instruction Sequencer

This block walks a display program held in memory and turns it into a stream of display blocks. Each instruction is read one byte at a time through a request/acknowledge port. The opcode always comes first and goes into an internal instruction register, which then decides whether two operand bytes follow. An instruction describes a group of lines: blank background lines, a jump to a new program address, or a block in one of the display modes 2 to 15. For each block the sequencer reports the mode, the number of lines it spans, and its two scroll-enable flags. On the last line of a block whose opcode carries the interrupt flag, it raises a one-cycle interrupt pulse.

Two address counters drive the fetches. The program counter is 16 bits wide, but only its low 10 bits count, so the program wraps inside a 1 KB window unless a jump moves it. The scan counter gives the address of the block data that a neighbouring fetch unit reads. Only its low 12 bits count, so it wraps inside a 4 KB window until an instruction reloads it. A CPU sets the program counter one byte at a time. A new pass through the program starts at the first line after vertical blank, and a jump can park the sequencer until that point.

Top module: `dlseq_top`

## Requirements
- R1: After reset no fetch is requested, no block is reported, the interrupt pulse is low and the scan address is 0. No fetch starts until `vblank_end` is pulsed.
- R2: A pulse on `cpu_wr_lo` or `cpu_wr_hi` loads `cpu_wdata` into the low or high byte of the program counter in the next cycle, so `mem_addr` follows even during a pending fetch. A `vblank_end` pulse abandons any block in progress and starts an opcode fetch at the current program counter.
- R3: An opcode whose low nibble is 0 is a one-byte blank block: mode 0, with a line count equal to bits 6..4 plus one (1 to 8).
- R4: An opcode whose low nibble is 1 is a three-byte jump. It loads the program counter from the next two bytes, low byte first, and reports a blank block of mode 0 and one line. If bit 6 is set, the next fetch waits for `vblank_end` instead of following after that line.
- R5: Low nibbles 2 to 15 are display modes reported on `blk_mode`. Bit 5 sets `blk_vscroll` and bit 4 sets `blk_hscroll`. Bit 6 makes a three-byte instruction that loads the scan counter, low byte first. Lines per block, by default, for modes 2..15: 8,10,8,16,8,16,8,4,4,2,1,2,1,1.
- R6: A one-byte display instruction leaves the scan address unchanged.
- R7: `blk_valid` pulses for one cycle per decoded instruction, while no fetch is requested. A block of N lines consumes N `line_start` pulses, and the next opcode fetch starts only after the N-th pulse.
- R8: When bit 7 of the opcode is set and `dli_en` is high at the block's N-th `line_start`, `dli_pulse` is high for one cycle after that edge. It is never raised on any other line, and never when `dli_en` is low.
- R9: Opcode fetches increment only the low 10 bits of the program counter, so the byte after address 0x23FF is fetched from 0x2000.
- R10: Each `scan_inc` pulse increments only the low 12 bits of the scan address, so 0x5FFE advances to 0x5FFF, 0x5000 and then 0x5001.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ack` arrives. Read data is taken in the cycle `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_lo | input | 1 | Write low byte of program counter |
| cpu_wr_hi | input | 1 | Write high byte of program counter |
| cpu_wdata | input | 8 | CPU write data |
| vblank_end | input | 1 | Pulse at the first line after vertical blank |
| line_start | input | 1 | Pulse at the start of each display line |
| dli_en | input | 1 | Display interrupt enable |
| scan_inc | input | 1 | Advance the scan address by one byte |
| mem_req | output | 1 | Instruction byte read request |
| mem_addr | output | 16 | Instruction byte address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 8 | Read data |
| blk_valid | output | 1 | One-cycle pulse: new block decoded |
| blk_mode | output | 4 | Block mode (0 for blank and jump) |
| blk_lines | output | 5 | Lines in the block, 1 to 16 |
| blk_vscroll | output | 1 | Vertical scroll enable |
| blk_hscroll | output | 1 | Horizontal scroll enable |
| scan_addr | output | 16 | Current scan address |
| dli_pulse | output | 1 | Display interrupt request pulse |

## Verification
The hardest case to reach from the ports is a CPU write to the program counter that lands while a fetch is still waiting for its acknowledge. The bench holds back the memory responder so the request stays pending, writes the low byte, and checks that the address moves at once and that the later acknowledge returns the byte from the new location. The parked state after a wait-jump is reached by playing out the jump's single line. The bench then counts fetches over an idle stretch, and only then pulses `vblank_end`. The window wraps are reached by placing instructions at the last byte of a window and loading the scan counter two bytes below its boundary.

// File: rtl/dlseq_pkg.sv
package dlseq_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_VB,
    ST_FETCH_OP,
    ST_FETCH_LO,
    ST_FETCH_HI,
    ST_ISSUE,
    ST_RUN
  } seq_state_t;

  localparam logic [3:0] OPK_BLANK = 4'h0;
  localparam logic [3:0] OPK_JUMP  = 4'h1;

  // True when the opcode is followed by a two-byte operand.
  function automatic logic op_has_operand(input logic [7:0] op);
    return (op[3:0] == OPK_JUMP) || ((op[3:0] != OPK_BLANK) && op[6]);
  endfunction

endpackage

// File: rtl/dlseq_wrap_ctr.sv
// Address register whose low CNT_W bits count while the upper bits stay fixed.
// Priority: byte writes, then full load, then increment.
module dlseq_wrap_ctr #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [7:0]        wr_byte,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] q
);
  localparam int HI_W = ADDR_W - 8;

  logic [CNT_W-1:0] cnt_next;
  assign cnt_next = q[CNT_W-1:0] + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) q[7:0]        <= wr_byte;
      if (wr_hi) q[ADDR_W-1:8] <= wr_byte[HI_W-1:0];
    end else if (load) begin
      q <= load_val;
    end else if (inc) begin
      q[CNT_W-1:0] <= cnt_next;
    end
  end
endmodule

// File: rtl/dlseq_decode.sv
// Combinational decode of the held opcode.
module dlseq_decode #(
  parameter logic [63:0] MODE_LINES = 64'h0010_1337_F7F7_9700
) (
  input  logic [7:0] op,
  output logic [3:0] mode,
  output logic [4:0] lines,
  output logic       vscr,
  output logic       hscr,
  output logic       is_jump,
  output logic       is_wait
);
  import dlseq_pkg::*;

  logic [3:0] tbl_m1;
  assign tbl_m1 = MODE_LINES[{op[3:0], 2'b00} +: 4];

  always_comb begin
    is_jump = (op[3:0] == OPK_JUMP);
    is_wait = is_jump && op[6];
    if (op[3:0] == OPK_BLANK) begin
      mode  = 4'h0;
      lines = {2'b00, op[6:4]} + 5'd1;
      vscr  = 1'b0;
      hscr  = 1'b0;
    end else if (is_jump) begin
      mode  = 4'h0;
      lines = 5'd1;
      vscr  = 1'b0;
      hscr  = 1'b0;
    end else begin
      mode  = op[3:0];
      lines = {1'b0, tbl_m1} + 5'd1;
      vscr  = op[5];
      hscr  = op[4];
    end
  end
endmodule

// File: rtl/dlseq_top.sv
module dlseq_top #(
  parameter int          ADDR_W     = 16,
  parameter int          PC_CNT_W   = 10,
  parameter int          SCAN_CNT_W = 12,
  parameter logic [63:0] MODE_LINES = 64'h0010_1337_F7F7_9700
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_lo,
  input  logic              cpu_wr_hi,
  input  logic [7:0]        cpu_wdata,
  input  logic              vblank_end,
  input  logic              line_start,
  input  logic              dli_en,
  input  logic              scan_inc,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              blk_valid,
  output logic [3:0]        blk_mode,
  output logic [4:0]        blk_lines,
  output logic              blk_vscroll,
  output logic              blk_hscroll,
  output logic [ADDR_W-1:0] scan_addr,
  output logic              dli_pulse
);
  import dlseq_pkg::*;

  seq_state_t state;
  logic [7:0] ir;
  logic [7:0] op_lo;
  logic [4:0] rem;

  logic [3:0] dec_mode;
  logic [4:0] dec_lines;
  logic       dec_vscr, dec_hscr, dec_jump, dec_wait;

  logic fetching, byte_taken, hi_taken;
  logic pc_load, scan_load;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] operand_val;

  assign fetching    = (state == ST_FETCH_OP) || (state == ST_FETCH_LO) ||
                       (state == ST_FETCH_HI);
  assign byte_taken  = fetching && mem_ack && !vblank_end;
  assign hi_taken    = byte_taken && (state == ST_FETCH_HI);
  assign pc_load     = hi_taken && dec_jump;
  assign scan_load   = hi_taken && !dec_jump;
  assign operand_val = {mem_rdata[ADDR_W-9:0], op_lo};

  dlseq_decode #(.MODE_LINES(MODE_LINES)) dec_i (
    .op      (ir),
    .mode    (dec_mode),
    .lines   (dec_lines),
    .vscr    (dec_vscr),
    .hscr    (dec_hscr),
    .is_jump (dec_jump),
    .is_wait (dec_wait)
  );

  dlseq_wrap_ctr #(.ADDR_W(ADDR_W), .CNT_W(PC_CNT_W)) pc_i (
    .clk      (clk),
    .rst      (rst),
    .wr_lo    (cpu_wr_lo),
    .wr_hi    (cpu_wr_hi),
    .wr_byte  (cpu_wdata),
    .load     (pc_load),
    .load_val (operand_val),
    .inc      (byte_taken),
    .q        (pc_q)
  );

  dlseq_wrap_ctr #(.ADDR_W(ADDR_W), .CNT_W(SCAN_CNT_W)) scan_i (
    .clk      (clk),
    .rst      (rst),
    .wr_lo    (1'b0),
    .wr_hi    (1'b0),
    .wr_byte  (8'h00),
    .load     (scan_load),
    .load_val (operand_val),
    .inc      (scan_inc),
    .q        (scan_addr)
  );

  assign mem_req  = fetching;
  assign mem_addr = pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_WAIT_VB;
      ir          <= '0;
      op_lo       <= '0;
      rem         <= '0;
      blk_valid   <= 1'b0;
      blk_mode    <= '0;
      blk_lines   <= '0;
      blk_vscroll <= 1'b0;
      blk_hscroll <= 1'b0;
      dli_pulse   <= 1'b0;
    end else begin
      blk_valid <= 1'b0;
      dli_pulse <= 1'b0;
      if (vblank_end) begin
        state <= ST_FETCH_OP;
      end else begin
        case (state)
          ST_FETCH_OP: if (mem_ack) begin
            ir    <= mem_rdata;
            state <= op_has_operand(mem_rdata) ? ST_FETCH_LO : ST_ISSUE;
          end
          ST_FETCH_LO: if (mem_ack) begin
            op_lo <= mem_rdata;
            state <= ST_FETCH_HI;
          end
          ST_FETCH_HI: if (mem_ack) begin
            state <= ST_ISSUE;
          end
          ST_ISSUE: begin
            blk_valid   <= 1'b1;
            blk_mode    <= dec_mode;
            blk_lines   <= dec_lines;
            blk_vscroll <= dec_vscr;
            blk_hscroll <= dec_hscr;
            rem         <= dec_lines;
            state       <= ST_RUN;
          end
          ST_RUN: if (line_start) begin
            rem <= rem - 5'd1;
            if (rem == 5'd1) begin
              dli_pulse <= ir[7] && dli_en;
              state     <= dec_wait ? ST_WAIT_VB : ST_FETCH_OP;
            end
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/dlseq_chk.sv
module dlseq_chk #(
  parameter int ADDR_W     = 16,
  parameter int SCAN_CNT_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr_lo,
  input logic              cpu_wr_hi,
  input logic              vblank_end,
  input logic              line_start,
  input logic              dli_en,
  input logic              scan_inc,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              blk_valid,
  input logic [ADDR_W-1:0] scan_addr,
  input logic              dli_pulse
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !mem_req && !blk_valid && !dli_pulse);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && !vblank_end && !cpu_wr_lo && !cpu_wr_hi
    |=> mem_req && $stable(mem_addr));

  a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
    blk_valid |=> !blk_valid);

  a_r7_no_fetch_at_issue: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> !mem_req);

  a_r8_dli_gated: assert property (@(posedge clk) disable iff (rst)
    dli_pulse |-> $past(dli_en) && $past(line_start));

  a_r10_scan_top_fixed: assert property (@(posedge clk) disable iff (rst)
    scan_inc && !mem_ack
    |=> scan_addr[ADDR_W-1:SCAN_CNT_W] == $past(scan_addr[ADDR_W-1:SCAN_CNT_W]));
endmodule

bind dlseq_top dlseq_chk #(.ADDR_W(ADDR_W), .SCAN_CNT_W(SCAN_CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cpu_wr_lo  (cpu_wr_lo),
  .cpu_wr_hi  (cpu_wr_hi),
  .vblank_end (vblank_end),
  .line_start (line_start),
  .dli_en     (dli_en),
  .scan_inc   (scan_inc),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .blk_valid  (blk_valid),
  .scan_addr  (scan_addr),
  .dli_pulse  (dli_pulse)
);

// File: tb/dlseq_top_tb_top.sv
`timescale 1ns/1ps
module dlseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr_lo = 1'b0, cpu_wr_hi = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        vblank_end = 1'b0, line_start = 1'b0, dli_en = 1'b0, scan_inc = 1'b0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'h00;
  logic        blk_valid, blk_vscroll, blk_hscroll, dli_pulse;
  logic [3:0]  blk_mode;
  logic [4:0]  blk_lines;
  logic [15:0] scan_addr;

  logic [7:0]  mem [0:4095];
  logic        stall = 1'b0;
  logic [15:0] last_addr = 16'h0;
  int          fetch_cnt = 0;
  int          n_tests = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  dlseq_top dut_i (
    .clk(clk), .rst(rst), .cpu_wr_lo(cpu_wr_lo), .cpu_wr_hi(cpu_wr_hi),
    .cpu_wdata(cpu_wdata), .vblank_end(vblank_end), .line_start(line_start),
    .dli_en(dli_en), .scan_inc(scan_inc), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .blk_valid(blk_valid),
    .blk_mode(blk_mode), .blk_lines(blk_lines), .blk_vscroll(blk_vscroll),
    .blk_hscroll(blk_hscroll), .scan_addr(scan_addr), .dli_pulse(dli_pulse)
  );

  // Memory responder: answers at the falling edge, consumed at the next rising edge.
  always @(negedge clk) begin
    mem_ack   <= mem_req && !stall;
    mem_rdata <= mem[mem_addr[11:0]];
    if (mem_req && !stall) begin
      last_addr <= mem_addr;
      fetch_cnt <= fetch_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    mem[a[11:0]] = d;
  endtask

  task automatic set_pc(input logic [15:0] a);
    @(negedge clk); cpu_wdata = a[7:0];  cpu_wr_lo = 1'b1;
    @(negedge clk); cpu_wr_lo = 1'b0; cpu_wdata = a[15:8]; cpu_wr_hi = 1'b1;
    @(negedge clk); cpu_wr_hi = 1'b0;
  endtask

  task automatic vb_pulse();
    vblank_end = 1'b1; @(negedge clk); vblank_end = 1'b0;
  endtask

  task automatic start_at(input logic [15:0] a);
    set_pc(a); vb_pulse();
  endtask

  task automatic one_line();
    line_start = 1'b1; @(negedge clk); line_start = 1'b0;
  endtask

  task automatic wait_blk(input string tag);
    bit seen = 0;
    for (int i = 0; i < 100; i++) begin
      if (blk_valid) begin seen = 1; break; end
      @(negedge clk);
    end
    chk({tag, " block issued"}, seen, 1'b1);
  endtask

  task automatic lines_n(input int n);
    for (int i = 0; i < n; i++) one_line();
  endtask

  task automatic t_reset();
    chk("R1 mem_req", mem_req, 1'b0);
    chk("R1 blk_valid", blk_valid, 1'b0);
    chk("R1 dli_pulse", dli_pulse, 1'b0);
    chk("R1 scan_addr", scan_addr, 16'h0000);
    repeat (10) @(negedge clk);
    chk("R1 no fetch before vblank_end", fetch_cnt, 0);
  endtask

  task automatic t_blank();
    int fc;
    put(16'h2010, 8'h70); put(16'h2011, 8'h20); put(16'h2012, 8'h00);
    start_at(16'h2010);
    wait_blk("R3");
    chk("R2 first fetch at pc", last_addr, 16'h2010);
    chk("R3 blank mode", blk_mode, 4'h0);
    chk("R3 blank 8 lines", blk_lines, 5'd8);
    @(negedge clk);
    chk("R7 valid is one cycle", blk_valid, 1'b0);
    fc = fetch_cnt;
    lines_n(7);
    chk("R7 no fetch before last line", fetch_cnt, fc);
    one_line();
    wait_blk("R3b");
    chk("R3 blank 3 lines", blk_lines, 5'd3);
    chk("R3 next fetch address", last_addr, 16'h2011);
  endtask

  task automatic t_display();
    put(16'h2020, 8'h4D); put(16'h2021, 8'h34); put(16'h2022, 8'h12);
    put(16'h2023, 8'h32); put(16'h2024, 8'h03);
    start_at(16'h2020);
    wait_blk("R5");
    chk("R5 mode D", blk_mode, 4'hD);
    chk("R5 mode D lines", blk_lines, 5'd2);
    chk("R5 scan load low first", scan_addr, 16'h1234);
    chk("R5 no scroll", {blk_vscroll, blk_hscroll}, 2'b00);
    lines_n(2);
    wait_blk("R5b");
    chk("R5 mode 2", blk_mode, 4'h2);
    chk("R5 mode 2 lines", blk_lines, 5'd8);
    chk("R5 scroll bits", {blk_vscroll, blk_hscroll}, 2'b11);
    chk("R6 scan unchanged", scan_addr, 16'h1234);
    lines_n(8);
    wait_blk("R5c");
    chk("R5 mode 3 lines", blk_lines, 5'd10);
  endtask

  task automatic t_jump();
    put(16'h2030, 8'h01); put(16'h2031, 8'h00); put(16'h2032, 8'h21);
    put(16'h2100, 8'h20);
    start_at(16'h2030);
    wait_blk("R4");
    chk("R4 jump mode", blk_mode, 4'h0);
    chk("R4 jump one line", blk_lines, 5'd1);
    chk("R4 jump scan untouched", scan_addr, 16'h1234);
    one_line();
    wait_blk("R4b");
    chk("R4 jump target", last_addr, 16'h2100);
    chk("R4 target block", blk_lines, 5'd3);
  endtask

  task automatic t_wait_jump();
    int fc;
    put(16'h2040, 8'h41); put(16'h2041, 8'h50); put(16'h2042, 8'h22);
    put(16'h2250, 8'h70);
    start_at(16'h2040);
    wait_blk("R4w");
    chk("R4 wait jump one line", blk_lines, 5'd1);
    one_line();
    fc = fetch_cnt;
    repeat (20) begin
      @(negedge clk);
      if (mem_req) fc = -1;
    end
    chk("R4 parked until vblank_end", fetch_cnt, fc);
    vb_pulse();
    wait_blk("R4w2");
    chk("R4 resume at target", last_addr, 16'h2250);
    chk("R4 resumed block", blk_lines, 5'd8);
  endtask

  task automatic t_dli();
    int pulses;
    put(16'h2060, 8'h82); put(16'h2061, 8'h82);
    dli_en = 1'b1;
    start_at(16'h2060);
    wait_blk("R8");
    pulses = 0;
    for (int i = 0; i < 7; i++) begin
      one_line();
      if (dli_pulse) pulses++;
    end
    chk("R8 no pulse before last line", pulses, 0);
    one_line();
    chk("R8 pulse on last line", dli_pulse, 1'b1);
    @(negedge clk);
    chk("R8 pulse one cycle", dli_pulse, 1'b0);
    wait_blk("R8b");
    dli_en = 1'b0;
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      one_line();
      if (dli_pulse) pulses++;
    end
    chk("R8 disabled gives no pulse", pulses, 0);
  endtask

  task automatic t_pc_wrap();
    put(16'h23FF, 8'h00); put(16'h2000, 8'h10); put(16'h2400, 8'h70);
    start_at(16'h23FF);
    wait_blk("R9");
    chk("R9 first block", blk_lines, 5'd1);
    one_line();
    wait_blk("R9b");
    chk("R9 wrapped fetch address", last_addr, 16'h2000);
    chk("R9 wrapped block", blk_lines, 5'd2);
  endtask

  task automatic t_scan_wrap();
    put(16'h2070, 8'h4E); put(16'h2071, 8'hFE); put(16'h2072, 8'h5F);
    start_at(16'h2070);
    wait_blk("R10");
    chk("R10 scan loaded", scan_addr, 16'h5FFE);
    scan_inc = 1'b1;
    repeat (3) @(negedge clk);
    scan_inc = 1'b0;
    chk("R10 scan wraps in 4K", scan_addr, 16'h5001);
  endtask

  task automatic t_stall_write();
    put(16'h2080, 8'h70); put(16'h2090, 8'h30); put(16'h2091, 8'h50);
    set_pc(16'h2080);
    stall = 1'b1;
    vb_pulse();
    repeat (4) @(negedge clk);
    chk("R11 request held", mem_req, 1'b1);
    chk("R11 address stable", mem_addr, 16'h2080);
    cpu_wdata = 8'h90; cpu_wr_lo = 1'b1;
    @(negedge clk); cpu_wr_lo = 1'b0;
    chk("R2 write moves pending address", mem_addr, 16'h2090);
    stall = 1'b0;
    wait_blk("R2");
    chk("R2 fetched from written pc", last_addr, 16'h2090);
    chk("R2 block from new pc", blk_lines, 5'd4);
    @(negedge clk);
    vb_pulse();
    wait_blk("R2b");
    chk("R2 vblank_end abandons block", last_addr, 16'h2091);
    chk("R2 restarted block", blk_lines, 5'd6);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_blank();
    t_display();
    t_jump();
    t_wait_jump();
    t_dli();
    t_pc_wrap();
    t_scan_wrap();
    t_stall_write();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule